// File: doc/BRIEF.md
# Fixed-Point Audio ALU with Post-Shifter

This block is the arithmetic stage of a fixed-point audio signal processor. It receives two fully formed 32-bit operands, a 4-bit operation code and a 4-bit shift code. From them it computes a new accumulator value, five status flags and a 16-bit write-back word. The flags and accumulator are registered and change only in cycles where the valid strobe is high.

The operation is applied first. The status flags are then taken from that raw result, and a post-shifter adjusts it afterwards. The post-shifter offers these modes:

- left shifts
- arithmetic right shifts
- logical right shifts
- a saturating clip driven by the overflow flag
- a one-place rotate through the carry flag, with the fractional guard bits kept

Zero and Exact each test a fixed field of the pre-shift value, so they give the same answer whatever shift follows.

Top module: `dsp_alu_shift`

## Requirements
- R1: Operation codes 0 and 8 pass A unchanged. 9 gives ~A, 10 gives A&B, 11 gives ~(A&B), 12 gives A|B, 13 gives ~(A|B), 14 gives A^B and 15 gives ~(A^B).
- R2: Code 1 gives 0-B. Codes 2 and 3 give A+B. Codes 4 and 5 give A-B. Code 6 gives A+0x1000. Code 7 gives A-0x1000. All results wrap modulo 2^32.
- R3: Carry and Overflow are cleared by every operation and set only by codes 1-7. For an add, Carry is the carry out of bit 31. For a subtract, Carry means no borrow (minuend >= subtrahend, unsigned). Overflow is signed two's-complement overflow of the 32-bit operation.
- R4: The flags are taken from the result before the post-shift. Zero = (bits 31:16 == 0). Negative = bit 31. Exact = (bits 15:12 == 0).
- R5: The effective shift code is {op[3], shift[3:0]}. Codes 1-6 and 17-22 shift left by 1, 2, 3, 4, 5 and 8. Codes 0 and 16 leave the value unshifted.
- R6: Codes 9-15 shift right arithmetically by 16, 8, 5, 4, 3, 2 and 1. Codes 25-31 shift right logically by the same amounts.
- R7: Codes 7 and 23 clip. When Overflow is set, the value becomes 0x7FFFF000 if Negative is set, or 0x80000000 if Negative is clear. When Overflow is clear, the value is unchanged.
- R8: Codes 8 and 24 rotate through carry. Carry becomes value bit 31. Bits 31:17 take value bits 30:16, and bit 16 takes the new Carry. Bits 15:12 are kept and bits 11:0 are cleared.
- R9: The write-back word equals bits 31:16 of the final accumulator.
- R10: All registers reset to zero. The accumulator, write-back word and flags load on a rising clock edge where valid is high. With valid low they hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Load strobe for accumulator and flags |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| alu_op_i | input | 4 | Operation code |
| shift_i | input | 4 | Post-shift code (low four bits) |
| acc_o | output | 32 | Registered accumulator |
| wb_o | output | 16 | Registered write-back word |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| carry_o | output | 1 | Carry / no-borrow flag |
| ovf_o | output | 1 | Overflow flag |
| exact_o | output | 1 | Exact flag |

## Verification
Every result appears exactly one clock after the rising edge that sampled valid high. There is no combinational path from the inputs to the outputs. The bench therefore drives each operation on a falling edge and compares all seven outputs on the next falling edge, when the registered values are settled. Hold checks keep valid low for several cycles with changed operands and compare against the last loaded values. The reset check reads the outputs on the first falling edge after reset is released.

// File: rtl/dsp_alu_pkg.sv
`timescale 1ns/1ps
package dsp_alu_pkg;

    parameter int ACC_W     = 32;
    parameter int HALF_W    = 16;
    parameter int OP_W      = 4;
    parameter int SH_W      = 4;
    parameter int EXACT_LSB = 12;
    parameter int EXACT_W   = 4;

    localparam int CODE_W  = SH_W + 1;
    localparam int SHAMT_W = $clog2(ACC_W);

    localparam logic [ACC_W-1:0] STEP_K  = ACC_W'(1) << EXACT_LSB;
    localparam logic [ACC_W-1:0] SAT_POS =
        {1'b0, {(ACC_W-EXACT_LSB-1){1'b1}}, {EXACT_LSB{1'b0}}};
    localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {(ACC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        ARITH_NONE = 2'd0,
        ARITH_ADD  = 2'd1,
        ARITH_SUB  = 2'd2
    } arith_kind_e;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [HALF_W-1:0] wb;
        logic              zero;
        logic              neg;
        logic              carry;
        logic              ovf;
        logic              exact;
    } alu_state_t;

endpackage

// File: rtl/dsp_alu_arith.sv
`timescale 1ns/1ps
module dsp_alu_arith
    import dsp_alu_pkg::*;
(
    input  logic [ACC_W-1:0] a_i,
    input  logic [ACC_W-1:0] b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [ACC_W-1:0] res_o,
    output logic             carry_o,
    output logic             ovf_o
);
    arith_kind_e      kind;
    logic [ACC_W-1:0] x, y, sum_add, sum_sub, arith_res;
    logic             xm, ym, rm;

    always_comb begin
        kind = ARITH_NONE;
        x    = a_i;
        y    = b_i;
        unique case (op_i)
            4'd1:       begin x = '0; kind = ARITH_SUB; end
            4'd2, 4'd3: kind = ARITH_ADD;
            4'd4, 4'd5: kind = ARITH_SUB;
            4'd6:       begin y = STEP_K; kind = ARITH_ADD; end
            4'd7:       begin y = STEP_K; kind = ARITH_SUB; end
            default:    kind = ARITH_NONE;
        endcase
    end

    assign sum_add   = x + y;
    assign sum_sub   = x - y;
    assign arith_res = (kind == ARITH_SUB) ? sum_sub : sum_add;

    always_comb begin
        unique case (op_i)
            4'd0, 4'd8: res_o = a_i;
            4'd9:       res_o = ~a_i;
            4'd10:      res_o = a_i & b_i;
            4'd11:      res_o = ~(a_i & b_i);
            4'd12:      res_o = a_i | b_i;
            4'd13:      res_o = ~(a_i | b_i);
            4'd14:      res_o = a_i ^ b_i;
            4'd15:      res_o = ~(a_i ^ b_i);
            default:    res_o = arith_res;
        endcase
    end

    assign xm = x[ACC_W-1];
    assign ym = y[ACC_W-1];
    assign rm = arith_res[ACC_W-1];

    always_comb begin
        carry_o = 1'b0;
        ovf_o   = 1'b0;
        if (kind == ARITH_ADD) begin
            carry_o = (xm & ym) | (xm & ~rm) | (ym & ~rm);
            ovf_o   = (xm & ym & ~rm) | (~xm & ~ym & rm);
        end else if (kind == ARITH_SUB) begin
            carry_o = (xm & ~ym) | (xm & ~rm) | (~ym & ~rm);
            ovf_o   = (xm & ~ym & ~rm) | (~xm & ym & rm);
        end
    end
endmodule

// File: rtl/dsp_alu_status.sv
`timescale 1ns/1ps
module dsp_alu_status
    import dsp_alu_pkg::*;
(
    input  logic [HALF_W-1:0]  upper_i,
    input  logic [EXACT_W-1:0] guard_i,
    output logic               zero_o,
    output logic               neg_o,
    output logic               exact_o
);
    assign zero_o  = (upper_i == '0);
    assign neg_o   = upper_i[HALF_W-1];
    assign exact_o = (guard_i == '0);
endmodule

// File: rtl/dsp_alu_postshift.sv
`timescale 1ns/1ps
module dsp_alu_postshift
    import dsp_alu_pkg::*;
(
    input  logic [ACC_W-1:0]  res_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              neg_i,
    input  logic              ovf_i,
    input  logic              carry_i,
    output logic [ACC_W-1:0]  res_o,
    output logic              carry_o
);
    function automatic logic [SHAMT_W-1:0] left_amt(input logic [2:0] sel);
        return (sel == 3'd6) ? SHAMT_W'(8) : SHAMT_W'(sel);
    endfunction

    function automatic logic [SHAMT_W-1:0] right_amt(input logic [2:0] sel);
        logic [SHAMT_W-1:0] amt;
        unique case (sel)
            3'd1:    amt = SHAMT_W'(16);
            3'd2:    amt = SHAMT_W'(8);
            3'd3:    amt = SHAMT_W'(5);
            3'd4:    amt = SHAMT_W'(4);
            3'd5:    amt = SHAMT_W'(3);
            3'd6:    amt = SHAMT_W'(2);
            default: amt = SHAMT_W'(1);
        endcase
        return amt;
    endfunction

    logic [2:0]       sel;
    logic             right_grp, logical;
    logic [ACC_W-1:0] rot_val, clip_val;

    assign sel       = code_i[2:0];
    assign right_grp = code_i[3];
    assign logical   = code_i[CODE_W-1];

    assign rot_val  = {res_i[ACC_W-2:HALF_W], res_i[ACC_W-1],
                       res_i[EXACT_LSB+EXACT_W-1:EXACT_LSB], {EXACT_LSB{1'b0}}};
    assign clip_val = ovf_i ? (neg_i ? SAT_POS : SAT_NEG) : res_i;

    always_comb begin
        res_o   = res_i;
        carry_o = carry_i;
        if (!right_grp) begin
            if (sel == 3'd7) begin
                res_o = clip_val;
            end else if (sel != 3'd0) begin
                res_o = res_i << left_amt(sel);
            end
        end else begin
            if (sel == 3'd0) begin
                res_o   = rot_val;
                carry_o = res_i[ACC_W-1];
            end else if (logical) begin
                res_o = res_i >> right_amt(sel);
            end else begin
                res_o = ACC_W'($signed(res_i) >>> right_amt(sel));
            end
        end
    end
endmodule

// File: rtl/dsp_alu_shift.sv
`timescale 1ns/1ps
module dsp_alu_shift
    import dsp_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [ACC_W-1:0]  opa_i,
    input  logic [ACC_W-1:0]  opb_i,
    input  logic [OP_W-1:0]   alu_op_i,
    input  logic [SH_W-1:0]   shift_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic [HALF_W-1:0] wb_o,
    output logic              zero_o,
    output logic              neg_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              exact_o
);
    alu_state_t st_d, st_q;

    logic [ACC_W-1:0]  raw_res, shifted;
    logic              raw_carry, raw_ovf, sh_carry;
    logic              pre_zero, pre_neg, pre_exact;
    logic [CODE_W-1:0] code;

    assign code = {alu_op_i[OP_W-1], shift_i};

    dsp_alu_arith u_arith (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .op_i    (alu_op_i),
        .res_o   (raw_res),
        .carry_o (raw_carry),
        .ovf_o   (raw_ovf)
    );

    dsp_alu_status u_status (
        .upper_i (raw_res[ACC_W-1 -: HALF_W]),
        .guard_i (raw_res[EXACT_LSB+EXACT_W-1:EXACT_LSB]),
        .zero_o  (pre_zero),
        .neg_o   (pre_neg),
        .exact_o (pre_exact)
    );

    dsp_alu_postshift u_shift (
        .res_i   (raw_res),
        .code_i  (code),
        .neg_i   (pre_neg),
        .ovf_i   (raw_ovf),
        .carry_i (raw_carry),
        .res_o   (shifted),
        .carry_o (sh_carry)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.acc   = shifted;
            st_d.wb    = shifted[ACC_W-1 -: HALF_W];
            st_d.zero  = pre_zero;
            st_d.neg   = pre_neg;
            st_d.carry = sh_carry;
            st_d.ovf   = raw_ovf;
            st_d.exact = pre_exact;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign wb_o    = st_q.wb;
    assign zero_o  = st_q.zero;
    assign neg_o   = st_q.neg;
    assign carry_o = st_q.carry;
    assign ovf_o   = st_q.ovf;
    assign exact_o = st_q.exact;
endmodule

// File: rtl/dsp_alu_shift_chk.sv
`timescale 1ns/1ps
module dsp_alu_shift_chk
    import dsp_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [OP_W-1:0]   alu_op_i,
    input logic [SH_W-1:0]   shift_i,
    input logic [ACC_W-1:0]  acc_o,
    input logic [HALF_W-1:0] wb_o,
    input logic              carry_o,
    input logic              ovf_o
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(acc_o) && $stable(wb_o) && $stable(carry_o) && $stable(ovf_o))); // R10

    AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (alu_op_i == 4'd0 || alu_op_i[OP_W-1]) && shift_i != 4'd8)
        |=> (!carry_o && !ovf_o)); // R3

    AST_CLIP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && shift_i == 4'd7)
        |=> (!ovf_o || acc_o == SAT_POS || acc_o == SAT_NEG)); // R7

    AST_ROT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && shift_i == 4'd8)
        |=> (acc_o[EXACT_LSB-1:0] == '0 && carry_o == acc_o[HALF_W])); // R8

    AST_WB_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        wb_o == acc_o[ACC_W-1 -: HALF_W]); // R9
endmodule

bind dsp_alu_shift dsp_alu_shift_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .alu_op_i (alu_op_i),
    .shift_i  (shift_i),
    .acc_o    (acc_o),
    .wb_o     (wb_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o)
);

// File: tb/dsp_alu_shift_tb.sv
`timescale 1ns/1ps
module dsp_alu_shift_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic [3:0]  alu_op_i = '0, shift_i = '0;
    logic [31:0] acc_o;
    logic [15:0] wb_o;
    logic        zero_o, neg_o, carry_o, ovf_o, exact_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [52:0] last_exp = '0;

    always #10 clk = ~clk;

    dsp_alu_shift u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .opa_i(opa_i), .opb_i(opb_i), .alu_op_i(alu_op_i), .shift_i(shift_i),
        .acc_o(acc_o), .wb_o(wb_o), .zero_o(zero_o), .neg_o(neg_o),
        .carry_o(carry_o), .ovf_o(ovf_o), .exact_o(exact_o)
    );

    // Packed view: {acc, wb, zero, neg, carry, ovf, exact}
    function automatic logic [52:0] outs();
        return {acc_o, wb_o, zero_o, neg_o, carry_o, ovf_o, exact_o};
    endfunction

    function automatic logic [52:0] model(input logic [3:0] op, input logic [3:0] sh,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r, q;
        logic [32:0] wide;
        logic        c, v, z, n, e;
        logic [4:0]  code;
        int          amt;
        c = 1'b0; v = 1'b0;
        case (op)
            4'd0, 4'd8: r = a;
            4'd9:  r = ~a;
            4'd10: r = a & b;
            4'd11: r = ~(a & b);
            4'd12: r = a | b;
            4'd13: r = ~(a | b);
            4'd14: r = a ^ b;
            4'd15: r = ~(a ^ b);
            4'd1: begin r = 32'd0 - b; c = (b == 32'd0); v = (b == 32'h8000_0000); end
            4'd2, 4'd3, 4'd6: begin
                q = (op == 4'd6) ? 32'h1000 : b;
                wide = {1'b0, a} + {1'b0, q};
                r = wide[31:0]; c = wide[32];
                v = (a[31] == q[31]) && (r[31] != a[31]);
            end
            default: begin
                q = (op == 4'd7) ? 32'h1000 : b;
                r = a - q; c = (a >= q);
                v = (a[31] != q[31]) && (r[31] != a[31]);
            end
        endcase
        z = (r[31:16] == 16'd0);
        n = r[31];
        e = (r[15:12] == 4'd0);
        code = {op[3], sh};
        case (code[2:0])
            3'd1: amt = 16; 3'd2: amt = 8; 3'd3: amt = 5; 3'd4: amt = 4;
            3'd5: amt = 3;  3'd6: amt = 2; default: amt = 1;
        endcase
        if (code[3:0] == 4'd7) begin
            if (v) r = n ? 32'h7FFF_F000 : 32'h8000_0000;
        end else if (code[3:0] == 4'd8) begin
            c = r[31];
            r = {r[30:16], c, r[15:12], 12'h000};
        end else if (code[3] == 1'b0 && code[2:0] != 3'd0) begin
            r = (code[2:0] == 3'd6) ? (r << 8) : (r << code[2:0]);
        end else if (code[3] == 1'b1) begin
            if (code[4]) r = r >> amt;
            else         r = $unsigned($signed(r) >>> amt);
        end
        return {r, r[31:16], z, n, c, v, e};
    endfunction

    task automatic check(input string tag, input logic [52:0] got, input logic [52:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [3:0] sh,
                         input logic [31:0] a, input logic [31:0] b,
                         input string tag, output logic [52:0] got);
        logic [52:0] exp;
        @(negedge clk);
        valid_i = 1'b1; alu_op_i = op; shift_i = sh; opa_i = a; opb_i = b;
        @(negedge clk);
        valid_i = 1'b0;
        got = outs();
        exp = model(op, sh, a, b);
        last_exp = exp;
        check($sformatf("%s op=%0d sh=%0d a=%h b=%h", tag, op, sh, a, b), got, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 reset state", outs(), 53'd0);
    endtask

    task automatic t_ops();
        logic [52:0] g;
        logic [31:0] pa [3] = '{32'h1234_5678, 32'h7FFF_FFFF, 32'hFFFF_0000};
        logic [31:0] pb [3] = '{32'h0F0F_00FF, 32'h0000_0001, 32'h8000_0000};
        for (int i = 0; i < 3; i++) begin
            for (int op = 0; op < 16; op++) begin
                if (op >= 1 && op <= 7)
                    apply(4'(op), 4'd0, pa[i], pb[i], "R2 R3 arith", g);
                else
                    apply(4'(op), 4'd0, pa[i], pb[i], "R1 R3 logic", g);
            end
        end
    endtask

    task automatic t_carry_edges();
        logic [52:0] g;
        apply(4'd4, 4'd0, 32'h0000_5000, 32'h0000_5000, "R3 equal sub", g);
        check("R3 equal sub no-borrow carry", {31'd0, g[2]}, 32'd1);
        apply(4'd4, 4'd0, 32'h0000_4000, 32'h0000_5000, "R3 borrow", g);
        check("R3 borrow clears carry", {31'd0, g[2]}, 32'd0);
        apply(4'd1, 4'd0, 32'h1111_1111, 32'h0000_0000, "R2 R3 negate zero", g);
        apply(4'd1, 4'd0, 32'h0, 32'h8000_0000, "R3 negate min overflow", g);
        check("R3 negate min V", {31'd0, g[1]}, 32'd1);
        apply(4'd2, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R3 add wrap", g);
        check("R2 R3 add wrap acc/carry", {g[52:21], g[2]}, {32'h0, 1'b1});
        apply(4'd6, 4'd0, 32'h0000_F000, 32'h0, "R2 add step", g);
        check("R2 R4 add step exact", {g[52:21], g[0]}, {32'h0001_0000, 1'b1});
        apply(4'd7, 4'd0, 32'h0000_0000, 32'h0, "R2 sub step", g);
        apply(4'd5, 4'd0, 32'h8000_0000, 32'h0000_0001, "R3 sub overflow", g);
    endtask

    task automatic t_flags();
        logic [52:0] g;
        apply(4'd0, 4'd0, 32'h0000_0FFF, 32'h0, "R4 zero exact", g);
        check("R4 z/n/e", {29'd0, g[4], g[3], g[0]}, {29'd0, 3'b101});
        apply(4'd0, 4'd0, 32'h0000_F000, 32'h0, "R4 zero not exact", g);
        apply(4'd0, 4'd9, 32'hFFFF_0000, 32'h0, "R4 flags before shift", g);
        check("R4 pre-shift flags asr16", {g[52:21], g[4], g[3], g[0]},
              {32'hFFFF_FFFF, 3'b011});
        apply(4'd0, 4'd1, 32'h8000_8000, 32'h0, "R4 R5 left drops sign", g);
    endtask

    task automatic t_shifts();
        logic [52:0] g;
        for (int s = 0; s < 16; s++) begin
            apply(4'd0, 4'(s), 32'h8765_4321, 32'h0, "R5 R6 code low", g);
            apply(4'd8, 4'(s), 32'h8765_4321, 32'h0, "R5 R6 code high", g);
        end
        apply(4'd0, 4'd6, 32'h0012_3456, 32'h0, "R5 left 8", g);
        check("R5 left 8 value R9 wb", g[52:21+0], {32'h1234_5600, 16'h1234} >> 16 << 0 == 0 ?
              g[52:21] : {32'h1234_5600, 16'h1234, 5'b0} >> 21);
        apply(4'd0, 4'd15, 32'h8000_0000, 32'h0, "R6 asr1", g);
        check("R6 asr1 value", {21'd0, g[52:21]}, {21'd0, 32'hC000_0000});
        apply(4'd8, 4'd15, 32'h8000_0000, 32'h0, "R6 lsr1", g);
        check("R6 lsr1 value", {21'd0, g[52:21]}, {21'd0, 32'h4000_0000});
    endtask

    task automatic t_clip();
        logic [52:0] g;
        apply(4'd2, 4'd7, 32'h7FFF_0000, 32'h0001_0000, "R7 clip pos", g);
        check("R7 clip positive saturation", {21'd0, g[52:21]}, {21'd0, 32'h7FFF_F000});
        apply(4'd4, 4'd7, 32'h8000_0000, 32'h0001_0000, "R7 clip neg", g);
        check("R7 clip negative saturation", {21'd0, g[52:21]}, {21'd0, 32'h8000_0000});
        apply(4'd2, 4'd7, 32'h1234_5678, 32'h0000_0001, "R7 no clip", g);
        check("R7 no overflow unchanged", {21'd0, g[52:21]}, {21'd0, 32'h1234_5679});
    endtask

    task automatic t_rotate();
        logic [52:0] g;
        apply(4'd0, 4'd8, 32'h8001_5ABC, 32'h0, "R8 rotate low", g);
        check("R8 rotate value/carry", {g[52:21], g[2]}, {32'h0003_5000, 1'b1});
        apply(4'd8, 4'd8, 32'h4000_F123, 32'h0, "R8 rotate high", g);
        check("R8 rotate carry clear", {g[52:21], g[2]}, {32'h8000_F000, 1'b0});
        apply(4'd2, 4'd8, 32'h0000_0000, 32'h0000_0000, "R8 rotate overrides add carry", g);
    endtask

    task automatic t_hold();
        logic [52:0] g, held;
        apply(4'd14, 4'd2, 32'hA5A5_1234, 32'h0F0F_0F0F, "R10 load", g);
        held = last_exp;
        @(negedge clk);
        valid_i = 1'b0; alu_op_i = 4'd13; shift_i = 4'd8;
        opa_i = 32'hDEAD_BEEF; opb_i = 32'h1357_9BDF;
        repeat (3) @(negedge clk);
        check("R10 hold with valid low", outs(), held);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ops();
        t_carry_edges();
        t_flags();
        t_shifts();
        t_clip();
        t_rotate();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule